// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the peripheral end of an 8-bit bus that carries the address and the data on the same wires. The host places an address on `ad_in` and pulses the active-low address strobe. When that strobe rises, the block captures the address, the active-low primary chip select and the active-low interrupt-acknowledge flag. The host then lowers the active-low data strobe. In a read, the block drives `ad_out` with `ad_oe` high for as long as the data strobe stays low. In a write, it takes the byte that is on the bus while the strobe is low and stores it when the strobe rises. The secondary chip select is active high and must be valid for the whole time the data strobe is low.

All bus inputs pass through one shared synchronizer chain clocked by the system clock, and every output is registered. A small register file inside the block holds the written values and supplies read data. Each write also shows up on the `reg_sel`/`wr_stb`/`wr_data` outputs, so neighbouring logic can follow it.

When both strobes are low at the same time, the block treats this as a hardware reset request and never as an access. The request must last a configurable number of clocks before it takes effect, so short glitches are filtered out. After each accepted access a recovery window follows, and new data strobes are not accepted until it has passed. An access whose captured acknowledge flag is active goes to the interrupt-acknowledge path: it returns an external vector and does not touch the register file.

Top module: `mux_bus_slave`

## Requirements
- R1: The address, the primary chip select and the acknowledge flag are captured when the address strobe rises. The captured address selects register `addr % NUM_REGS` (default 8 registers, `reg_sel` = address bits [2:0]). A write to a register followed by a read of the same register returns the written byte.
- R2: An access is accepted only when all three hold: the captured primary select is low, `cs1` is high when the data strobe falls, and the captured address bits above the index match `BASE_ADDR` (default 0x20, so addresses 0x20–0x27). Otherwise `ad_oe` stays 0 and no write takes place.
- R3: A write (`rw`=0) stores the last byte sampled while the data strobe was low. It is committed once, after the strobe rises, as a single one-cycle `wr_stb` pulse with the matching `reg_sel`/`wr_data`. If `cs1` drops at any point while the strobe is low, the write is discarded.
- R4: A read (`rw`=1) drives `ad_oe`=1 and `ad_out` = the selected register while the data strobe is low. After the strobe rises, `ad_oe` returns to 0 and `ad_out` to 0.
- R5: When both strobes are low at the same time, no access starts: no drive and no write.
- R6: `dev_reset` rises only after both strobes have been low together for `RST_FILTER` consecutive sampled clocks (default 4). It stays high while that condition lasts, and it clears every register to zero. Shorter coincidences have no effect.
- R7: A data strobe that falls within `RECOVERY_CLKS` clocks (default 6) after an accepted access ended is ignored. A data strobe that falls after that window is served normally.
- R8: When the captured acknowledge flag is active (`intack_n`=0), the access ignores both chip selects and `rw`. It drives `iack_vec` on `ad_out`, gives exactly one `iack_stb` pulse, and never writes a register.
- R9: After `rst_n` is released, `ad_oe`, `wr_stb`, `iack_stb` and `dev_reset` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Multiplexed address/data from the host |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Output enable for `ad_out` |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs0_n | input | 1 | Primary chip select, active low, captured with the address |
| cs1 | input | 1 | Secondary chip select, active high, valid during the data strobe |
| intack_n | input | 1 | Interrupt acknowledge, active low, captured with the address |
| iack_vec | input | 8 | Vector returned in acknowledge accesses |
| reg_sel | output | 3 | Captured register index |
| wr_stb | output | 1 | One-cycle write commit pulse |
| wr_data | output | 8 | Byte committed with `wr_stb` |
| iack_stb | output | 1 | One-cycle pulse at the start of an acknowledge access |
| dev_reset | output | 1 | Filtered reset request from both strobes being low together |

## Verification
The bench sweeps all 256 addresses for reads and writes. A decoder that compared too few or too many address bits would then drive or write outside the 0x20–0x27 window, and an off-by-one index would return the wrong pattern byte. It drops `cs1` in the middle of a write strobe, which catches a design that checks the select only at the falling edge and stores the byte anyway. It holds both strobes low for two clocks and then for twelve, which separates a missing glitch filter (spurious register clear) from a missing reset path (registers survive). It also retries a read two clocks after an access: a design without a recovery window would drive the bus there.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   // Snapshot of all host-side bus lines, passed through one synchronizer chain
   typedef struct packed {
      logic [7:0] ad;
      logic       as_n;
      logic       ds_n;
      logic       rw;
      logic       cs0_n;
      logic       cs1;
      logic       intack_n;
   } mbs_bus_t;

   localparam mbs_bus_t MBS_BUS_IDLE = '{
      ad:       8'h00,
      as_n:     1'b1,
      ds_n:     1'b1,
      rw:       1'b0,
      cs0_n:    1'b1,
      cs1:      1'b0,
      intack_n: 1'b1
   };

   // Kind of access currently in progress
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2,
      CYC_IACK  = 2'd3
   } mbs_cyc_e;

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int             W      = 14,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stg[i] <= INIT;
               end else if (i == 0) begin
                  stg[i] <= d;
               end else begin
                  stg[i] <= stg[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (clr) begin
               regs[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
               regs[g] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = regs[ridx];

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
   import mbs_pkg::*;
#(
   parameter int         ADDR_W        = 3,
   parameter logic [7:0] BASE_ADDR     = 8'h20,
   parameter int         RST_FILTER    = 4,
   parameter int         RECOVERY_CLKS = 6,
   localparam int        RCW           = $clog2(RECOVERY_CLKS + 1),
   localparam int        FCW           = $clog2(RST_FILTER + 1),
   localparam logic [7:0] HI_MASK      = 8'(8'hFF << ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbs_bus_t          bus,
   input  logic [7:0]        rd_data,
   input  logic [7:0]        iack_vec,
   output logic [7:0]        ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-1:0] reg_sel,
   output logic              wr_stb,
   output logic [7:0]        wr_data,
   output logic              iack_stb,
   output logic              dev_reset
);

   logic           prev_as_n, prev_ds_n;
   logic [7:0]     lat_addr;
   logic           lat_cs0_n, lat_iack, lat_valid;
   mbs_cyc_e       cyc, cyc_n;
   logic           cs1_ok;
   logic [7:0]     wd_hold;
   logic [RCW-1:0] rec_cnt;
   logic [FCW-1:0] flt_cnt;
   logic           reset_q;

   logic     coincident, as_rise, ds_fall, ds_rise;
   logic     addr_hit, sel_ok, accept, commit, flt_full, drive_n;
   mbs_cyc_e start_kind;

   always_comb begin
      coincident = !bus.as_n && !bus.ds_n;
      as_rise    = !prev_as_n && bus.as_n;
      ds_fall    = prev_ds_n && !bus.ds_n && bus.as_n;
      ds_rise    = !prev_ds_n && bus.ds_n;
      addr_hit   = (lat_addr & HI_MASK) == (BASE_ADDR & HI_MASK);
      sel_ok     = lat_iack || (!lat_cs0_n && bus.cs1 && addr_hit);
      accept     = ds_fall && lat_valid && (rec_cnt == '0) && !reset_q && sel_ok;
      start_kind = lat_iack ? CYC_IACK : (bus.rw ? CYC_READ : CYC_WRITE);
      commit     = ds_rise && (cyc == CYC_WRITE) && cs1_ok;
      flt_full   = flt_cnt >= FCW'(RST_FILTER - 1);
   end

   always_comb begin
      cyc_n = cyc;
      if (coincident || reset_q) begin
         cyc_n = CYC_IDLE;
      end else if (accept) begin
         cyc_n = start_kind;
      end else if (ds_rise) begin
         cyc_n = CYC_IDLE;
      end
      drive_n = (cyc_n == CYC_IACK) || ((cyc_n == CYC_READ) && bus.cs1);
   end

   // Strobe history and address phase capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_as_n <= 1'b1;
         prev_ds_n <= 1'b1;
         lat_addr  <= '0;
         lat_cs0_n <= 1'b1;
         lat_iack  <= 1'b0;
         lat_valid <= 1'b0;
      end else begin
         prev_as_n <= bus.as_n;
         prev_ds_n <= bus.ds_n;
         if (reset_q) begin
            lat_valid <= 1'b0;
         end else if (as_rise && bus.ds_n) begin
            lat_addr  <= bus.ad;
            lat_cs0_n <= bus.cs0_n;
            lat_iack  <= !bus.intack_n;
            lat_valid <= 1'b1;
         end
      end
   end

   // Data phase tracking, write commit and recovery window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc      <= CYC_IDLE;
         cs1_ok   <= 1'b0;
         wd_hold  <= '0;
         rec_cnt  <= '0;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
         iack_stb <= 1'b0;
         ad_oe    <= 1'b0;
         ad_out   <= '0;
      end else begin
         cyc      <= cyc_n;
         iack_stb <= accept && lat_iack;
         wr_stb   <= commit;
         if (commit) begin
            wr_data <= wd_hold;
         end
         if (!bus.ds_n) begin
            wd_hold <= bus.ad;
         end
         if (accept) begin
            cs1_ok <= 1'b1;
         end else if ((cyc != CYC_IDLE) && !bus.ds_n && !bus.cs1) begin
            cs1_ok <= 1'b0;
         end
         if (ds_rise && (cyc != CYC_IDLE)) begin
            rec_cnt <= RCW'(RECOVERY_CLKS);
         end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
         end
         ad_oe  <= drive_n;
         ad_out <= drive_n ? ((cyc_n == CYC_IACK) ? iack_vec : rd_data) : 8'h00;
      end
   end

   // Coincident-strobe reset filter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_cnt <= '0;
         reset_q <= 1'b0;
      end else begin
         if (!coincident) begin
            flt_cnt <= '0;
         end else if (!flt_full) begin
            flt_cnt <= flt_cnt + 1'b1;
         end
         reset_q <= coincident && flt_full;
      end
   end

   assign reg_sel   = lat_addr[ADDR_W-1:0];
   assign dev_reset = reset_q;

endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
   import mbs_pkg::*;
#(
   parameter int         NUM_REGS      = 8,
   parameter logic [7:0] BASE_ADDR     = 8'h20,
   parameter int         SYNC_STAGES   = 2,
   parameter int         RST_FILTER    = 4,
   parameter int         RECOVERY_CLKS = 6,
   localparam int        ADDR_W        = $clog2(NUM_REGS),
   localparam int        BUS_W         = $bits(mbs_bus_t)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        ad_in,
   output logic [7:0]        ad_out,
   output logic              ad_oe,
   input  logic              as_n,
   input  logic              ds_n,
   input  logic              rw,
   input  logic              cs0_n,
   input  logic              cs1,
   input  logic              intack_n,
   input  logic [7:0]        iack_vec,
   output logic [ADDR_W-1:0] reg_sel,
   output logic              wr_stb,
   output logic [7:0]        wr_data,
   output logic              iack_stb,
   output logic              dev_reset
);

   // Elaboration-time parameter checks
   generate
      if ((NUM_REGS < 2) || (NUM_REGS > 128) || ((NUM_REGS & (NUM_REGS - 1)) != 0)) begin : g_bad_regs
         $error("NUM_REGS must be a power of two in 2..128");
      end
      if ((BASE_ADDR & 8'(NUM_REGS - 1)) != 0) begin : g_bad_base
         $error("BASE_ADDR must be aligned to NUM_REGS");
      end
      if ((SYNC_STAGES < 0) || (SYNC_STAGES > 4)) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (RST_FILTER < 1) begin : g_bad_filter
         $error("RST_FILTER must be at least 1");
      end
      if (RECOVERY_CLKS < 1) begin : g_bad_recovery
         $error("RECOVERY_CLKS must be at least 1");
      end
   endgenerate

   mbs_bus_t raw, smp;
   logic     s_as_n, s_ds_n;
   logic [7:0] rd_data;

   always_comb begin
      raw.ad       = ad_in;
      raw.as_n     = as_n;
      raw.ds_n     = ds_n;
      raw.rw       = rw;
      raw.cs0_n    = cs0_n;
      raw.cs1      = cs1;
      raw.intack_n = intack_n;
   end

   mbs_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES),
      .INIT   (MBS_BUS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (smp)
   );

   assign s_as_n = smp.as_n;
   assign s_ds_n = smp.ds_n;

   mbs_ctrl #(
      .ADDR_W        (ADDR_W),
      .BASE_ADDR     (BASE_ADDR),
      .RST_FILTER    (RST_FILTER),
      .RECOVERY_CLKS (RECOVERY_CLKS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus       (smp),
      .rd_data   (rd_data),
      .iack_vec  (iack_vec),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .reg_sel   (reg_sel),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .iack_stb  (iack_stb),
      .dev_reset (dev_reset)
   );

   mbs_regfile #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (8)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (dev_reset),
      .we    (wr_stb),
      .widx  (reg_sel),
      .wdata (wr_data),
      .ridx  (reg_sel),
      .rdata (rd_data)
   );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s_as_n,
   input logic             s_ds_n,
   input logic             ad_oe,
   input logic             wr_stb,
   input logic             iack_stb,
   input logic             dev_reset,
   input logic [SEL_W-1:0] reg_sel
);

   p_oe_needs_ds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> !$past(s_ds_n));

   p_sel_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe && $past(ad_oe)) |-> $stable(reg_sel));

   p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   p_iack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iack_stb |=> !iack_stb);

   p_iack_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iack_stb |-> !wr_stb);

   p_reset_from_coincident_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_reset) |-> $past(!s_as_n && !s_ds_n));

   p_no_access_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset |-> (!ad_oe && !wr_stb));

endmodule

bind mux_bus_slave mbs_checker #(.SEL_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_as_n    (s_as_n),
   .s_ds_n    (s_ds_n),
   .ad_oe     (ad_oe),
   .wr_stb    (wr_stb),
   .iack_stb  (iack_stb),
   .dev_reset (dev_reset),
   .reg_sel   (reg_sel)
);

// File: tb/mux_bus_slave_test.sv
module mux_bus_slave_test;

   localparam int         NREG  = 8;
   localparam logic [7:0] BASE  = 8'h20;
   localparam int         SYNC  = 2;
   localparam int         FILT  = 4;
   localparam int         RECOV = 6;
   localparam int         G     = SYNC + 3;
   localparam logic [7:0] VEC   = 8'h5C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic       as_n = 1'b1, ds_n = 1'b1, rw = 1'b0;
   logic       cs0_n = 1'b1, cs1 = 1'b0, intack_n = 1'b1;
   logic [7:0] iack_vec = VEC;
   logic [2:0] reg_sel;
   logic       wr_stb;
   logic [7:0] wr_data;
   logic       iack_stb;
   logic       dev_reset;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int iack_cnt = 0;
   int rst_seen = 0;
   logic [2:0] last_sel = '0;
   logic [7:0] last_wdat = '0;
   bit done = 0;

   always #2 clk = ~clk;

   mux_bus_slave #(
      .NUM_REGS      (NREG),
      .BASE_ADDR     (BASE),
      .SYNC_STAGES   (SYNC),
      .RST_FILTER    (FILT),
      .RECOVERY_CLKS (RECOV)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ad_in     (ad_in),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .as_n      (as_n),
      .ds_n      (ds_n),
      .rw        (rw),
      .cs0_n     (cs0_n),
      .cs1       (cs1),
      .intack_n  (intack_n),
      .iack_vec  (iack_vec),
      .reg_sel   (reg_sel),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .iack_stb  (iack_stb),
      .dev_reset (dev_reset)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         wr_cnt++;
         last_sel  = reg_sel;
         last_wdat = wr_data;
      end
      if (iack_stb) iack_cnt++;
      if (dev_reset) rst_seen++;
   end

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic bit hit(logic [7:0] a);
      return (a & 8'hF8) == BASE;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic addr_phase(logic [7:0] a, logic c0n, logic ian);
      @(negedge clk);
      ad_in = a; cs0_n = c0n; intack_n = ian; as_n = 1'b0;
      repeat (G) @(negedge clk);
      as_n = 1'b1;
      repeat (G) @(negedge clk);
      cs0_n = 1'b1; intack_n = 1'b1;
   endtask

   task automatic do_read(logic [7:0] a, logic c0n, logic c1, logic ian,
                          output logic oe_mid, output logic [7:0] d_mid,
                          output logic oe_end);
      addr_phase(a, c0n, ian);
      ad_in = 8'h00; rw = 1'b1; cs1 = c1; ds_n = 1'b0;
      repeat (G) @(negedge clk);
      oe_mid = ad_oe; d_mid = ad_out;
      ds_n = 1'b1;
      repeat (G) @(negedge clk);
      oe_end = ad_oe;
      cs1 = 1'b0; rw = 1'b0;
      repeat (RECOV + 3) @(negedge clk);
   endtask

   task automatic do_write(logic [7:0] a, logic [7:0] d, logic c0n, logic c1,
                           logic ian, bit drop_cs1);
      addr_phase(a, c0n, ian);
      ad_in = d; rw = 1'b0; cs1 = c1; ds_n = 1'b0;
      repeat (2) @(negedge clk);
      if (drop_cs1) cs1 = 1'b0;
      repeat (G - 2) @(negedge clk);
      ds_n = 1'b1;
      repeat (G) @(negedge clk);
      cs1 = 1'b0; ad_in = 8'h00;
      repeat (RECOV + 3) @(negedge clk);
   endtask

   task automatic coincide(int n, output logic rst_mid, output logic oe_mid);
      @(negedge clk);
      as_n = 1'b0; ds_n = 1'b0;
      repeat (n) @(negedge clk);
      rst_mid = dev_reset; oe_mid = ad_oe;
      as_n = 1'b1; ds_n = 1'b1;
      repeat (G + RECOV) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
      finish_run();
   end

   initial begin
      logic om, oe2;
      logic [7:0] dm;
      logic rm;
      int w0, i0, r0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: reset state
      check(!ad_oe && !wr_stb && !iack_stb && !dev_reset, "R9 outputs idle",
            {ad_oe, wr_stb, iack_stb, dev_reset}, 0);
      for (int i = 0; i < NREG; i++) begin
         do_read(BASE + 8'(i), 1'b0, 1'b1, 1'b1, om, dm, oe2);
         check(om && dm == 8'h00, "R9 register zero after reset", dm, 0);
      end

      // R1, R3: write each register, watch the commit pulse
      for (int i = 0; i < NREG; i++) begin
         w0 = wr_cnt;
         do_write(BASE + 8'(i), pat(i), 1'b0, 1'b1, 1'b1, 0);
         check(wr_cnt == w0 + 1, "R3 one commit pulse", wr_cnt - w0, 1);
         check(last_sel == 3'(i) && last_wdat == pat(i), "R1 R3 commit index/data",
               {last_sel, last_wdat}, {3'(i), pat(i)});
      end

      // R2, R4, R1: read sweep over every address
      for (int a = 0; a < 256; a++) begin
         do_read(8'(a), 1'b0, 1'b1, 1'b1, om, dm, oe2);
         if (hit(8'(a))) begin
            check(om && dm == pat(a & 7), "R4 R1 read data", dm, pat(a & 7));
         end else begin
            check(!om && dm == 8'h00, "R2 unmapped read not driven", om, 0);
         end
         check(!oe2, "R4 release after strobe rise", oe2, 0);
      end

      // R2: write sweep over every unmapped address
      w0 = wr_cnt;
      for (int a = 0; a < 256; a++) begin
         if (!hit(8'(a))) do_write(8'(a), 8'hFF, 1'b0, 1'b1, 1'b1, 0);
      end
      check(wr_cnt == w0, "R2 unmapped writes dropped", wr_cnt - w0, 0);

      // R2: chip select combinations
      w0 = wr_cnt;
      do_write(BASE + 8'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 0);
      do_write(BASE + 8'd2, 8'hAA, 1'b0, 1'b0, 1'b1, 0);
      do_write(BASE + 8'd2, 8'hAA, 1'b1, 1'b0, 1'b1, 0);
      check(wr_cnt == w0, "R2 deselected writes dropped", wr_cnt - w0, 0);
      do_read(BASE + 8'd2, 1'b0, 1'b0, 1'b1, om, dm, oe2);
      check(!om, "R2 cs1 low read not driven", om, 0);
      do_read(BASE + 8'd2, 1'b1, 1'b1, 1'b1, om, dm, oe2);
      check(!om, "R2 cs0 high read not driven", om, 0);
      do_read(BASE + 8'd2, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      check(om && dm == pat(2), "R2 register unchanged", dm, pat(2));

      // R3: cs1 drop during the data strobe discards the write
      w0 = wr_cnt;
      do_write(BASE + 8'd4, 8'h11, 1'b0, 1'b1, 1'b1, 1);
      check(wr_cnt == w0, "R3 cs1 drop discards write", wr_cnt - w0, 0);
      do_read(BASE + 8'd4, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      check(om && dm == pat(4), "R3 register kept after cs1 drop", dm, pat(4));

      // R7: recovery window
      do_read(BASE + 8'd1, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      rw = 1'b1; cs1 = 1'b1; ds_n = 1'b0;
      repeat (G) @(negedge clk);
      ds_n = 1'b1;
      repeat (2) @(negedge clk);
      ds_n = 1'b0;
      repeat (G) @(negedge clk);
      check(!ad_oe, "R7 strobe inside recovery ignored", ad_oe, 0);
      ds_n = 1'b1;
      repeat (RECOV + 4) @(negedge clk);
      ds_n = 1'b0;
      repeat (G) @(negedge clk);
      check(ad_oe && ad_out == pat(1), "R7 strobe after recovery served", ad_out, pat(1));
      ds_n = 1'b1;
      repeat (G + RECOV + 3) @(negedge clk);
      rw = 1'b0; cs1 = 1'b0;

      // R8: interrupt acknowledge, selects and rw ignored
      i0 = iack_cnt; w0 = wr_cnt;
      do_read(8'h00, 1'b1, 1'b0, 1'b0, om, dm, oe2);
      check(om && dm == VEC, "R8 vector driven", dm, VEC);
      check(iack_cnt == i0 + 1, "R8 one acknowledge pulse", iack_cnt - i0, 1);
      do_write(BASE + 8'd3, 8'h77, 1'b0, 1'b1, 1'b0, 0);
      check(wr_cnt == w0 && iack_cnt == i0 + 2, "R8 acknowledge never writes",
            wr_cnt - w0, 0);
      do_read(BASE + 8'd3, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      check(om && dm == pat(3), "R8 register untouched", dm, pat(3));

      // R5, R6: short coincidence is filtered
      r0 = rst_seen; w0 = wr_cnt;
      coincide(2, rm, om);
      check(rst_seen == r0 && !om, "R6 R5 glitch ignored", rst_seen - r0, 0);
      check(wr_cnt == w0, "R5 no write from coincidence", wr_cnt - w0, 0);
      do_read(BASE + 8'd5, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      check(om && dm == pat(5), "R6 registers survive glitch", dm, pat(5));

      // R6: long coincidence resets and clears
      coincide(12, rm, om);
      check(rm && !om, "R6 R5 reset asserted without drive", {rm, om}, 2);
      check(!dev_reset, "R6 reset released", dev_reset, 0);
      for (int i = 0; i < NREG; i++) begin
         do_read(BASE + 8'(i), 1'b0, 1'b1, 1'b1, om, dm, oe2);
         check(om && dm == 8'h00, "R6 register cleared", dm, 0);
      end

      // R1: accesses work again after the reset request
      do_write(BASE + 8'd6, 8'h3C, 1'b0, 1'b1, 1'b1, 0);
      do_read(BASE + 8'd6, 1'b0, 1'b1, 1'b1, om, dm, oe2);
      check(om && dm == 8'h3C, "R1 write/read after reset", dm, 8'h3C);

      finish_run();
   end

endmodule